// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block breaks a long application vector of `N` elements into strips that a vector unit can execute one at a time. No strip holds more elements than the machine's maximum vector length `MVL`, which is a power-of-two build parameter. The odd-sized strip of `N mod MVL` elements is issued first. Every strip after it carries exactly `MVL` elements. When `N` is an exact multiple of `MVL`, the empty leading strip is skipped.

Each strip command carries three values: a vector-length value, the index of the first element in the strip, and a flag that marks the final strip. Commands leave through a valid/ready handshake. The length output acts as the live vector-length register. It holds the element count of the strip on offer, and it reads zero while no strip is offered.

The controller has three states:
- `ST_IDLE` waits for a start pulse.
  - `GO_ISSUE` leaves it when `N` is non-zero.
  - `GO_EMPTY` leaves it when `N` is zero.
- `ST_ISSUE` offers strips.
  - `STAY_ISSUE` keeps it there while a strip is stalled or a non-final strip is accepted.
  - `GO_FINISH` leaves it when the final strip is accepted.
- `ST_FINISH` drives the one-cycle done pulse.
  - `GO_IDLE` returns it to `ST_IDLE` unconditionally.

Top module: `strip_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd_valid_o` and `done_o` are 0, `cmd_vl_o` is 0 and `cmd_base_o` is 0.
- R2: `cmd_vl_o` never exceeds `MVL`. It is 0 in every cycle in which `cmd_valid_o` is 0.
- R3: When `N mod MVL` is non-zero, the first strip carries `N mod MVL` elements and every later strip carries `MVL`.
- R4: When `N` is a non-zero multiple of `MVL`, exactly `N/MVL` strips are issued, each of `MVL` elements.
- R5: A start with `N` = 0 issues no strip. `done_o` is 1 in the cycle after the start edge.
- R6: The first strip has base index 0. Each later strip's base equals the previous base plus the previous strip's length.
- R7: While `cmd_valid_o` is 1 and `cmd_ready_i` is 0, the valid, length, base and last outputs stay unchanged. The sequencer moves on only on a cycle where both are 1.
- R8: `cmd_last_o` is 1 on the final strip of a sequence and 0 on every other offered strip.
- R9: `done_o` is 1 for exactly one cycle, the cycle after the final strip is accepted. A start pulse in the cycle after that begins a new sequence.
- R10: A start pulse that arrives while strips are being issued or while `done_o` is 1 has no effect on the current or later commands.
- R11: The lengths of all accepted strips of a sequence add up to `N`.
- R12: The first strip is offered in the cycle after the start edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a sequence; sampled only in `ST_IDLE` |
| total_len_i | input | LEN_W | Total element count `N`, captured with `start_i` |
| cmd_ready_i | input | 1 | Consumer accepts the offered strip |
| cmd_valid_o | output | 1 | A strip command is on offer |
| cmd_vl_o | output | $clog2(MVL+1) | Vector length of the offered strip, 0 when none |
| cmd_base_o | output | LEN_W | Index of the strip's first element |
| cmd_last_o | output | 1 | Offered strip is the final one |
| done_o | output | 1 | One-cycle pulse after the final strip is accepted |

## Verification
The lengths tried are zero, below `MVL`, exactly `MVL`, one above it, exact multiples, and odd mixes up to about a thousand elements. These separate the remainder-first path, the skipped-empty-strip path and the no-strip path. Each length runs under four consumer behaviours: always ready, alternating ready, sparse pseudo-random ready, and a long stall. The stall cases show that nothing advances or changes without a handshake. A second start injected during a busy sequence shows that the running commands and their base indices are left untouched.

// File: rtl/strip_seq_pkg.sv
package strip_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_FINISH = 2'd2
    } strip_state_e;

endpackage

// File: rtl/strip_split.sv
// Works out the length of the leading strip from the total count.
// MVL is a power of two, so the remainder is just the low bits.
module strip_split #(
    parameter int LEN_W = 16,
    parameter int MVL   = 8,
    localparam int VL_W = $clog2(MVL + 1)
) (
    input  logic [LEN_W-1:0] len_i,
    output logic [VL_W-1:0]  first_vl_o,
    output logic             zero_len_o
);

    localparam logic [VL_W-1:0] MVL_V = VL_W'(MVL);

    assign zero_len_o = (len_i == '0);

    generate
        if (MVL == 1) begin : g_unit
            assign first_vl_o = MVL_V;
        end else begin : g_mask
            localparam int SH = $clog2(MVL);
            logic [SH-1:0] rem;
            assign rem        = len_i[SH-1:0];
            assign first_vl_o = (rem != '0) ? VL_W'(rem) : MVL_V;
        end
    endgenerate

endmodule

// File: rtl/strip_track.sv
// Holds the live vector-length register, the base index and the elements left.
module strip_track #(
    parameter int LEN_W = 16,
    parameter int MVL   = 8,
    localparam int VL_W = $clog2(MVL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [VL_W-1:0]  first_vl_i,
    input  logic             accept_i,
    output logic [VL_W-1:0]  vl_o,
    output logic [LEN_W-1:0] base_o,
    output logic             last_o
);

    localparam logic [VL_W-1:0] MVL_V = VL_W'(MVL);

    logic [VL_W-1:0]  vl_q;
    logic [LEN_W-1:0] base_q;
    logic [LEN_W-1:0] left_q;
    logic [LEN_W-1:0] vl_ext;

    assign vl_ext = LEN_W'(vl_q);
    assign last_o = (vl_q != '0) && (left_q == vl_ext);
    assign vl_o   = vl_q;
    assign base_o = base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vl_q   <= '0;
            base_q <= '0;
            left_q <= '0;
        end else if (load_i) begin
            vl_q   <= first_vl_i;
            base_q <= '0;
            left_q <= len_i;
        end else if (accept_i) begin
            base_q <= base_q + vl_ext;
            left_q <= left_q - vl_ext;
            vl_q   <= last_o ? '0 : MVL_V;
        end
    end

    // R2: the length register stays within its legal range
    p_vl_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vl_q <= MVL_V);

    // R6: an accepted strip moves the base on by its own length
    p_base_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && !load_i) |=> (base_q == $past(base_q) + LEN_W'($past(vl_q))));

endmodule

// File: rtl/strip_ctrl.sv
// Sequencer state machine: idle, issuing strips, done pulse.
module strip_ctrl
    import strip_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic zero_len_i,
    input  logic ready_i,
    input  logic last_i,
    output logic load_o,
    output logic valid_o,
    output logic accept_o,
    output logic done_o
);

    strip_state_e state_q;
    strip_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = zero_len_i ? ST_FINISH : ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (ready_i && last_i) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        load_o   = 1'b0;
        valid_o  = 1'b0;
        accept_o = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_o = start_i && !zero_len_i;
            end
            ST_ISSUE: begin
                valid_o  = 1'b1;
                accept_o = ready_i;
            end
            ST_FINISH: begin
                done_o = 1'b1;
            end
            default: begin
                done_o = 1'b0;
            end
        endcase
    end

    // R9: done lasts a single cycle
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: a stalled strip stays on offer
    p_stall_keeps_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> valid_o);

    // R10: a start while issuing does not reload the strip registers
    p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> !load_o);

endmodule

// File: rtl/strip_seq.sv
module strip_seq #(
    parameter int LEN_W = 16,
    parameter int MVL   = 8,
    localparam int VL_W = $clog2(MVL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] total_len_i,
    input  logic             cmd_ready_i,
    output logic             cmd_valid_o,
    output logic [VL_W-1:0]  cmd_vl_o,
    output logic [LEN_W-1:0] cmd_base_o,
    output logic             cmd_last_o,
    output logic             done_o
);

    localparam logic [VL_W-1:0] MVL_V = VL_W'(MVL);

    generate
        if ((MVL < 1) || ((MVL & (MVL - 1)) != 0)) begin : g_bad_mvl
            $error("strip_seq: MVL must be a power of two");
        end
    endgenerate

    logic [VL_W-1:0] first_vl;
    logic            zero_len;
    logic            load;
    logic            accept;
    logic            last;

    strip_split #(.LEN_W(LEN_W), .MVL(MVL)) u_split (
        .len_i      (total_len_i),
        .first_vl_o (first_vl),
        .zero_len_o (zero_len)
    );

    strip_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .zero_len_i (zero_len),
        .ready_i    (cmd_ready_i),
        .last_i     (last),
        .load_o     (load),
        .valid_o    (cmd_valid_o),
        .accept_o   (accept),
        .done_o     (done_o)
    );

    strip_track #(.LEN_W(LEN_W), .MVL(MVL)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .len_i      (total_len_i),
        .first_vl_i (first_vl),
        .accept_i   (accept),
        .vl_o       (cmd_vl_o),
        .base_o     (cmd_base_o),
        .last_o     (last)
    );

    assign cmd_last_o = cmd_valid_o && last;

    // R7: a stalled command holds every field
    p_hold_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i) |=>
            ($stable(cmd_vl_o) && $stable(cmd_base_o) && $stable(cmd_last_o)));

    // R3: after a non-final strip is taken, the next one is full length
    p_full_after_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_ready_i && !cmd_last_o) |=> (cmd_valid_o && cmd_vl_o == MVL_V));

    // R2: the length reads zero when nothing is offered
    p_idle_vl_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid_o |-> (cmd_vl_o == '0));

    // R9: accepting the final strip leads to done
    p_done_follows_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_ready_i && cmd_last_o) |=> (done_o && !cmd_valid_o));

endmodule

// File: tb/strip_seq_tb_top.sv
module strip_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 16;
    localparam int MVL        = 8;
    localparam int VL_W       = $clog2(MVL + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [LEN_W-1:0] n_in = '0;
    logic             ready = 1'b0;
    logic             cmd_valid;
    logic [VL_W-1:0]  cmd_vl;
    logic [LEN_W-1:0] cmd_base;
    logic             cmd_last;
    logic             done;

    strip_seq #(.LEN_W(LEN_W), .MVL(MVL)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .total_len_i (n_in),
        .cmd_ready_i (ready),
        .cmd_valid_o (cmd_valid),
        .cmd_vl_o    (cmd_vl),
        .cmd_base_o  (cmd_base),
        .cmd_last_o  (cmd_last),
        .done_o      (done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        int vl;
        int base;
        bit last;
    } strip_t;

    strip_t      exp_q[$];
    bit          m_done = 1'b0;
    bit          m_next;
    bit          stalled = 1'b0;
    bit          cmp_en = 1'b0;
    bit          inj_active = 1'b0;
    int          seq_n = 0;
    int          sum_vl = 0;
    int          ready_mode = 0;
    int unsigned seed = 32'h1234_5678;
    int          checks = 0;
    int          fails = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model: list of expected strips built at start
    task automatic build(input int n);
        int r;
        int b;
        strip_t s;
        r = n % MVL;
        b = 0;
        seq_n = n;
        if (r != 0) begin
            s.vl = r; s.base = 0; s.last = 1'b0;
            exp_q.push_back(s);
            b = r;
        end
        while (b < n) begin
            s.vl = MVL; s.base = b; s.last = 1'b0;
            exp_q.push_back(s);
            b += MVL;
        end
        exp_q[exp_q.size() - 1].last = 1'b1;
    endtask

    always @(negedge clk) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        case (ready_mode)
            0: ready <= 1'b1;
            1: ready <= ~ready;
            2: ready <= (seed[17:16] == 2'b00);
            default: ready <= 1'b0;
        endcase
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q.delete();
            m_done = 1'b0;
            stalled = 1'b0;
        end else begin
            if (cmd_valid && ready) sum_vl += int'(cmd_vl);
            m_next = 1'b0;
            stalled = 1'b0;
            if (exp_q.size() > 0) begin
                if (ready) begin
                    void'(exp_q.pop_front());
                    if (exp_q.size() == 0) m_next = 1'b1;
                end else begin
                    stalled = 1'b1;
                end
            end else if (!m_done && start) begin
                if (n_in == '0) begin
                    seq_n = 0;
                    m_next = 1'b1;
                end else begin
                    build(int'(n_in));
                end
            end
            m_done = m_next;
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            string sfx;
            sfx = {stalled ? " R7" : "", inj_active ? " R10" : ""};
            chk(cmd_valid == (exp_q.size() > 0), {"R3 R4 R5 R12 valid", sfx},
                int'(cmd_valid), int'(exp_q.size() > 0));
            if (exp_q.size() > 0) begin
                chk(int'(cmd_vl) == exp_q[0].vl, {"R3 R4 vl", sfx}, int'(cmd_vl), exp_q[0].vl);
                chk(int'(cmd_base) == exp_q[0].base, {"R6 base", sfx}, int'(cmd_base), exp_q[0].base);
                chk(cmd_last == exp_q[0].last, {"R8 last", sfx}, int'(cmd_last), int'(exp_q[0].last));
            end else begin
                chk(cmd_vl == '0, "R2 idle vl", int'(cmd_vl), 0);
            end
            chk(done == m_done, (seq_n == 0) ? "R5 done" : "R9 done", int'(done), int'(m_done));
            if (m_done) begin
                chk(sum_vl == seq_n, "R11 length sum", sum_vl, seq_n);
                sum_vl = 0;
            end
        end
    end

    task automatic run(input int n, input bit inject);
        n_in  = LEN_W'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 20000 && !done; i++) begin
            @(negedge clk);
            if (inject && i == 2) begin
                inj_active = 1'b1;
                n_in  = LEN_W'(5);
                start = 1'b1;
            end else if (inject && i == 3) begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        inj_active = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!cmd_valid && !done, "R1 reset valid/done", int'(cmd_valid || done), 0);
        chk(cmd_vl == '0 && cmd_base == '0, "R1 reset vl/base", int'(cmd_vl) + int'(cmd_base), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cmd_valid && !done, "R1 after reset valid/done", int'(cmd_valid || done), 0);
        chk(cmd_vl == '0 && cmd_base == '0, "R1 after reset vl/base", int'(cmd_vl) + int'(cmd_base), 0);
        cmp_en = 1'b1;

        ready_mode = 0;
        run(0, 1'b0);
        run(1, 1'b0);
        run(8, 1'b0);
        run(9, 1'b0);
        run(21, 1'b0);
        run(16, 1'b0);

        ready_mode = 1;
        run(23, 1'b0);
        run(64, 1'b0);

        ready_mode = 2;
        run(13, 1'b0);
        run(40, 1'b0);
        run(7, 1'b0);
        run(30, 1'b1);

        // R7: long stall before any strip is taken
        ready_mode = 3;
        n_in  = LEN_W'(20);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        ready_mode = 0;
        for (int i = 0; i < 100 && !done; i++) @(negedge clk);
        @(negedge clk);

        ready_mode = 2;
        run(0, 1'b0);
        ready_mode = 0;
        run(1003, 1'b0);
        run(3, 1'b0);

        cmp_en = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule